// File: doc/BRIEF.md
# Countdown Timer Peripheral

This block is a single-channel down-counting timer for a small word-addressed register bus. Software stores a reload value and a control word. While the run bit of the control word is set, the timer lowers a readable current-count register by one on every tick. A tick is a clock cycle in which the tick-enable input is high. When the count sits at zero, the reload bit decides what happens. With the bit set, the count is refilled from the stored reload value and an interrupt pulse is produced. With the bit clear, the count rests at zero. The count register can be read but never written. After reset it only becomes nonzero through a reload.

The bus carries one full word per access, together with a byte-count field. Only four-byte accesses at one of the four word offsets are accepted. Byte lane 0 (bits 7:0 of the data buses) carries the byte at the lowest address, and that byte is the most significant byte of the register. Read data comes out of a register one cycle after the read strobe. An access that is refused raises the error output for one cycle and changes nothing.

Top module: `cdt_timer`

## Requirements
- R1: After reset the scratch, control, reload and count registers read as zero, and irq, bus_err and bus_rdata are all low.
- R2: The scratch (offset 0x0), control (offset 0x4) and reload (offset 0x8) registers accept four-byte writes and return the stored value on bus_rdata in the cycle after a four-byte read.
- R3: Byte lane k of bus_wdata and bus_rdata (bits 8k+7:8k) holds register byte 3-k, so lane 0 carries the most significant byte.
- R4: The count changes only on a tick in which control bit 2 (run) is already set. A write that sets bit 2 has no effect on the tick in the same cycle.
- R5: On a tick while running, a nonzero count decreases by exactly one. Cycles with tick_en low leave it unchanged.
- R6: On a tick while running, a zero count is loaded from the reload register if control bit 0 (reload) is set, and otherwise stays zero.
- R7: irq is high in the cycle after any tick that leaves the count at zero while control bit 0 is set, whether or not the run bit is set. It is low otherwise.
- R8: Writing the reload register does not alter a count already in progress. The new value is used at the next reload.
- R9: A write to offset 0xC (count) or to any offset other than 0x0, 0x4, 0x8 or 0xC raises bus_err for one cycle and leaves every register unchanged.
- R10: An access whose bus_size is not 4 raises bus_err for one cycle. Such a write changes no register, and such a read returns zero.
- R11: A read of an unmapped offset raises bus_err for one cycle and returns zero on bus_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Qualifies the current cycle as a timer tick |
| bus_addr | input | 4 | Byte offset of the access |
| bus_size | input | 3 | Number of bytes in the access; only 4 is legal |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, byte lane 0 is the most significant byte |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse after a refused access |
| irq | output | 1 | Interrupt pulse, one cycle per qualifying tick |

## Verification
The embedded properties assume that a cycle never carries a read and a write together. The checks on refused accesses and on read data depend on that assumption. They also assume that the bus strobes are known whenever reset is released. The stimulus issues one access at a time and follows each with an idle cycle. It holds tick_en low during register accesses except in one case, where a single tick is made to coincide with the control write that starts the timer. This way every count value can be predicted and read back exactly.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [1:0] {
        SEL_SCRATCH = 2'd0,
        SEL_CTRL    = 2'd1,
        SEL_RELOAD  = 2'd2,
        SEL_COUNT   = 2'd3
    } reg_sel_e;

    localparam int CTRL_RELOAD_BIT = 0;
    localparam int CTRL_RUN_BIT    = 2;

endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
    import cdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int SIZE_W    = 3,
    parameter int ACC_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              wr,
    input  logic              rd,
    output reg_sel_e          sel,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              bad
);

    logic size_ok;
    logic mapped;

    always_comb begin
        size_ok = (size == SIZE_W'(ACC_BYTES));
        mapped  = (addr[1:0] == 2'b00) && ((addr >> 4) == '0);
        sel     = reg_sel_e'(addr[3:2]);
        rd_ok   = rd && size_ok && mapped;
        wr_ok   = wr && size_ok && mapped && (sel != SEL_COUNT);
        bad     = (rd && !rd_ok) || (wr && !wr_ok);
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         reload_en,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick && run) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - W'(1);
            end else if (reload_en) begin
                st_d.cnt = period;
            end
        end
        st_d.irq = tick && reload_en && (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign irq = st_q.irq;

    // R4: no running tick, no change of the count
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && run) |=> $stable(st_q.cnt));

    // R5: running tick on a nonzero count lowers it by one
    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - W'(1)));

    // R6: refill from the reload value at zero
    p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && reload_en && st_q.cnt == '0) |=> (st_q.cnt == $past(period)));

    // R6: without reload the zero count rests
    p_rest_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !reload_en && st_q.cnt == '0) |=> (st_q.cnt == '0));

    // R7: a pulse needs a tick with reload set in the previous cycle
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> ($past(tick) && $past(reload_en)));

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] cnt_val;
    logic              wr_ok;
    logic              rd_ok;
    logic              bad;
    reg_sel_e          sel;

    // lane k of the bus carries register byte LANES-1-k
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_word[DATA_W-1-8*g -: 8]   = bus_wdata[8*g +: 8];
        assign bus_rdata[8*g +: 8]          = regs_q.rdata[DATA_W-1-8*g -: 8];
    end

    cdt_decode #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .ACC_BYTES (LANES)
    ) decode_i (
        .addr  (bus_addr),
        .size  (bus_size),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .sel   (sel),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .bad   (bad)
    );

    cdt_counter #(
        .W (DATA_W)
    ) counter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .run       (regs_q.ctrl[CTRL_RUN_BIT]),
        .reload_en (regs_q.ctrl[CTRL_RELOAD_BIT]),
        .period    (regs_q.reload),
        .cnt       (cnt_val),
        .irq       (irq)
    );

    always_comb begin
        regs_d = regs_q;
        case (sel)
            SEL_SCRATCH: rd_word = regs_q.scratch;
            SEL_CTRL:    rd_word = regs_q.ctrl;
            SEL_RELOAD:  rd_word = regs_q.reload;
            default:     rd_word = cnt_val;
        endcase
        regs_d.rdata = rd_ok ? rd_word : '0;
        regs_d.err   = bad;
        if (wr_ok) begin
            case (sel)
                SEL_SCRATCH: regs_d.scratch = wr_word;
                SEL_CTRL:    regs_d.ctrl    = wr_word;
                SEL_RELOAD:  regs_d.reload  = wr_word;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_err = regs_q.err;

    // R9: a refused access leaves the writable registers untouched
    p_refused_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.err |-> ($stable(regs_q.scratch) && $stable(regs_q.ctrl) && $stable(regs_q.reload)));

    // R11: a refused read returns zero
    p_refused_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.err && $past(bus_rd)) |-> (bus_rdata == '0));

    // R2: no read strobe, no read data
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [31:0] data;
        bit          err;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    bit   acc_seen = 1'b0;

    always #10 clk = ~clk;

    cdt_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq       (irq)
    );

    function automatic logic [31:0] lanes(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per access, one cycle after the strobe
    always @(posedge clk) acc_seen <= bus_rd | bus_wr;

    always @(negedge clk) begin
        if (acc_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard empty", 32'h0, 32'h1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(bus_err == e.err, {e.req, " err"}, 32'(bus_err), 32'(e.err));
                if (e.is_rd) chk(bus_rdata == e.data, {e.req, " rdata"}, bus_rdata, e.data);
            end
        end
    end

    // driver: raw lane data, one access followed by one idle cycle
    task automatic access(input bit rd, input logic [3:0] a, input logic [31:0] raw,
                          input logic [2:0] sz, input logic [31:0] exp_raw,
                          input bit exp_err, input string req);
        exp_t e;
        @(negedge clk);
        bus_addr  = a;
        bus_size  = sz;
        bus_wdata = raw;
        bus_wr    = !rd;
        bus_rd    = rd;
        e.is_rd = rd; e.data = exp_raw; e.err = exp_err; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v, input string req);
        access(1'b0, a, lanes(v), 3'd4, 32'h0, 1'b0, req);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] v, input string req);
        access(1'b1, a, 32'h0, 3'd4, lanes(v), 1'b0, req);
    endtask

    task automatic tick(input bit exp_irq, input string req);
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        chk(irq == exp_irq, req, 32'(irq), 32'(exp_irq));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
        chk(bus_err == 1'b0, "R1 err", 32'(bus_err), 32'h0);
        chk(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        rd(4'h0, 32'h0, "R1 scratch");
        rd(4'h4, 32'h0, "R1 ctrl");
        rd(4'h8, 32'h0, "R1 reload");
        rd(4'hC, 32'h0, "R1 count");

        // R2: read/write of the three writable registers
        wr(4'h0, 32'hA5A5_1234, "R2 wr scratch");
        rd(4'h0, 32'hA5A5_1234, "R2 rd scratch");
        wr(4'h8, 32'h1234_5678, "R2 wr reload");
        rd(4'h8, 32'h1234_5678, "R2 rd reload");
        wr(4'h4, 32'hF0F0_0002, "R2 wr ctrl");
        rd(4'h4, 32'hF0F0_0002, "R2 rd ctrl");
        wr(4'h4, 32'h0, "R2 clear ctrl");

        // R3: raw lanes, lane 3 holds the least significant byte
        access(1'b0, 4'h8, 32'h0300_0000, 3'd4, 32'h0, 1'b0, "R3 raw wr");
        access(1'b1, 4'h8, 32'h0, 3'd4, 32'h0300_0000, 1'b0, "R3 raw rd");
        wr(4'h4, 32'h5, "R4 start");
        rd(4'hC, 32'h0, "R6 before refill");
        tick(1'b0, "R6 refill irq");
        rd(4'hC, 32'h3, "R3 R6 refill value");
        tick(1'b0, "R5 irq");
        rd(4'hC, 32'h2, "R5 dec");
        tick(1'b0, "R5 irq");
        rd(4'hC, 32'h1, "R5 dec");
        tick(1'b1, "R7 R3 irq at zero");
        rd(4'hC, 32'h0, "R5 zero");
        tick(1'b0, "R7 irq after refill");
        rd(4'hC, 32'h3, "R6 refill again");

        // R8: reload change mid-count
        wr(4'h8, 32'h7, "R8 wr reload");
        tick(1'b0, "R8 irq");
        rd(4'hC, 32'h2, "R8 count unaffected");
        tick(1'b0, "R8 irq");
        tick(1'b1, "R7 irq");
        tick(1'b0, "R8 irq");
        rd(4'hC, 32'h7, "R8 new reload used");

        // R4: stopped timer holds, start takes effect one cycle later
        wr(4'h4, 32'h1, "R4 stop");
        tick(1'b0, "R4 irq");
        rd(4'hC, 32'h7, "R4 held while stopped");
        tick_en = 1'b1;
        wr(4'h4, 32'h5, "R4 start with tick");
        tick_en = 1'b0;
        rd(4'hC, 32'h7, "R4 no change on start cycle");
        tick(1'b0, "R4 irq");
        rd(4'hC, 32'h6, "R4 first running tick");

        // R6: no reload, count rests at zero
        wr(4'h4, 32'h4, "R6 run only");
        for (int i = 0; i < 6; i++) tick(1'b0, "R6 no irq");
        rd(4'hC, 32'h0, "R6 reached zero");
        tick(1'b0, "R6 no irq at zero");
        rd(4'hC, 32'h0, "R6 stays zero");

        // R7: pulse without run
        wr(4'h4, 32'h1, "R7 reload only");
        tick(1'b1, "R7 irq while stopped");
        tick(1'b1, "R7 irq each tick");
        rd(4'hC, 32'h0, "R7 count still zero");

        // R9: refused writes
        access(1'b0, 4'hC, lanes(32'h55), 3'd4, 32'h0, 1'b1, "R9 wr count");
        rd(4'hC, 32'h0, "R9 count unchanged");
        access(1'b0, 4'h6, lanes(32'hDEAD_BEEF), 3'd4, 32'h0, 1'b1, "R9 wr unmapped");
        rd(4'h0, 32'hA5A5_1234, "R9 scratch unchanged");
        rd(4'h4, 32'h1, "R9 ctrl unchanged");
        rd(4'h8, 32'h7, "R9 reload unchanged");

        // R11: refused read of an unmapped offset
        access(1'b1, 4'h6, 32'h0, 3'd4, 32'h0, 1'b1, "R11 rd unmapped");

        // R10: wrong access size
        access(1'b0, 4'h8, lanes(32'h99), 3'd2, 32'h0, 1'b1, "R10 short wr");
        rd(4'h8, 32'h7, "R10 reload unchanged");
        access(1'b1, 4'h0, 32'h0, 3'd1, 32'h0, 1'b1, "R10 short rd");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule